// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block decides, for each DRAM rank on its own, when to drop the clock-enable line and when to raise it again. Every rank has a programmable inactivity limit. Once the rank has seen that many consecutive cycles with no read and no pending request, the controller lowers its CKE and sends a NOP in the same cycle. From the next cycle on it floats the rank's command, address and data pins. Only CKE, held low, and ODT stay driven. The bank state at the moment of entry picks the flavour of power-down. If any bank is open, the rank goes into active power-down and keeps its pages. If every bank is precharged, it goes into precharge power-down, and a global selection picks the fast-exit or slow-exit variant.

A pending request wakes the rank, but only after the rank has stayed down for a programmable minimum dwell. Wake-up raises CKE together with a NOP. The controller then withholds command-ready for a programmable number of cycles. For slow-exit wake-ups it also withholds data-ready for a separate, longer delay. The surrounding command scheduler uses the ready outputs to gate its own issue. The selected flavour is reported per rank so that the scheduler knows whether open pages survived.

Top module: `dram_pd_ctrl`

## Requirements
- R1: After reset every rank is awake: cke=1, nop_stb=0, pin_tristate=0, cmd_rdy=1, data_rdy=1, pd_kind=0.
- R2: An awake rank whose enable bit is 1 and whose limit L is non-zero powers down after the L-th consecutive clock edge at which both req and rd for that rank are 0. Any req or rd restarts the count. A limit of 0 or an enable bit of 0 keeps the rank awake.
- R3: The first power-down cycle shows cke=0, nop_stb=1, pin_tristate=0, cmd_rdy=0, data_rdy=0.
- R4: Every later power-down cycle shows cke=0, nop_stb=0, pin_tristate=1, cmd_rdy=0, data_rdy=0.
- R5: pd_kind (2 bits per rank, rank r at bits 2r+1:2r) reports the flavour captured at the entry edge. 1 means any bank was open. 2 means all banks were precharged and cfg_slow_exit was 0. 3 means all banks were precharged and cfg_slow_exit was 1. The value stays unchanged until the rank is awake again, when it reads 0.
- R6: A rank stays down for at least cfg_min_pd cycles. With req held, wake-up starts right after the cfg_min_pd-th power-down cycle, or right away if the dwell is already longer.
- R7: The first wake cycle (index 0) shows cke=1, nop_stb=1, pin_tristate=0.
- R8: cmd_rdy rises at wake index cfg_cmd_dly. For pd_kind 1 or 2, data_rdy rises in the same cycle.
- R9: For pd_kind 3, data_rdy rises at wake index max(cfg_cmd_dly, cfg_data_dly).
- R10: When data_rdy rises the rank is awake on the next edge, and its idle count starts again from zero.
- R11: Ranks are independent: one rank's state, requests and reads do not affect another rank's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pd_en | input | NUM_RANKS | Per-rank power-down enable |
| cfg_slow_exit | input | 1 | Choose slow-exit for precharged ranks |
| cfg_idle_limit | input | NUM_RANKS*TMR_W | Per-rank inactivity limit, rank r at bits r*TMR_W upward |
| cfg_min_pd | input | DLY_W | Minimum power-down dwell in cycles |
| cfg_cmd_dly | input | DLY_W | Wake-to-command delay |
| cfg_data_dly | input | DLY_W | Slow-exit wake-to-data delay |
| req | input | NUM_RANKS | Pending request per rank |
| rd | input | NUM_RANKS | Read activity per rank |
| bank_open | input | NUM_RANKS | Any bank open in the rank |
| cke | output | NUM_RANKS | Clock enable per rank |
| nop_stb | output | NUM_RANKS | NOP driven this cycle |
| pin_tristate | output | NUM_RANKS | Float the rank's command, address and data pins |
| cmd_rdy | output | NUM_RANKS | Commands may be issued |
| data_rdy | output | NUM_RANKS | Data transfers may be issued |
| pd_kind | output | 2*NUM_RANKS | Power-down flavour per rank |

## Verification
Two things can meet in one cycle: a rank's inactivity limit can expire on the same edge that a request or read arrives, and a wake request can reach a rank in the very cycle it enters power-down, before its minimum dwell has passed. The random phase drives short limits and dense, independent request and read patterns across ranks, so both collisions occur often. A behavioural per-rank model compares every output on every cycle. The model decides that activity wins over expiry and that the dwell is honoured. Directed steps place a request on the entry cycle and count the low-CKE cycles that follow.

// File: rtl/dram_pd_pkg.sv
package dram_pd_pkg;
  typedef enum logic [1:0] {
    RK_ON   = 2'd0,
    RK_DOWN = 2'd1,
    RK_WAKE = 2'd2
  } rank_st_e;

  typedef enum logic [1:0] {
    PDK_NONE = 2'd0,
    PDK_ACT  = 2'd1,
    PDK_FAST = 2'd2,
    PDK_SLOW = 2'd3
  } pd_kind_e;
endpackage

// File: rtl/dram_pd_idle_timer.sv
module dram_pd_idle_timer #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [TMR_W-1:0] limit,
  output logic             expire
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             limit_nz;

  assign limit_nz = |limit;
  assign expire   = !hold && limit_nz && (cnt_q == (limit - 1'b1));

  always_comb begin
    if (hold || expire) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dram_pd_sat_ctr.sv
module dram_pd_sat_ctr #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;
  logic         at_max;

  assign at_max = &cnt;

  always_comb begin
    if (clr)         cnt_d = '0;
    else if (at_max) cnt_d = cnt;
    else             cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/dram_pd_rank.sv
module dram_pd_rank
  import dram_pd_pkg::*;
#(
  parameter int TMR_W = 8,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             slow_sel,
  input  logic [TMR_W-1:0] idle_limit,
  input  logic [DLY_W-1:0] min_pd,
  input  logic [DLY_W-1:0] cmd_dly,
  input  logic [DLY_W-1:0] data_dly,
  input  logic             req,
  input  logic             rd,
  input  logic             bank_open,
  output logic             cke,
  output logic             nop_stb,
  output logic             pin_tristate,
  output logic             cmd_rdy,
  output logic             data_rdy,
  output logic [1:0]       kind
);
  localparam int CW = DLY_W + 1;

  rank_st_e         st_q, st_d;
  pd_kind_e         kind_q, kind_d;
  logic             kind_en;
  logic             expire, tmr_hold;
  logic [DLY_W-1:0] dwell, wake_idx;
  logic [DLY_W-1:0] data_lim;
  logic             dwell_met, data_met, cmd_met;

  // inactivity timer runs only while awake and quiet
  assign tmr_hold = (st_q != RK_ON) || req || rd || !en;

  dram_pd_idle_timer #(.TMR_W(TMR_W)) u_idle (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (tmr_hold),
    .limit  (idle_limit),
    .expire (expire)
  );

  dram_pd_sat_ctr #(.W(DLY_W)) u_dwell (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != RK_DOWN),
    .cnt   (dwell)
  );

  dram_pd_sat_ctr #(.W(DLY_W)) u_wake (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_q != RK_WAKE),
    .cnt   (wake_idx)
  );

  assign dwell_met = ({1'b0, dwell} + CW'(1)) >= {1'b0, min_pd};
  assign data_lim  = (kind_q == PDK_SLOW && data_dly > cmd_dly) ? data_dly : cmd_dly;
  assign cmd_met   = wake_idx >= cmd_dly;
  assign data_met  = wake_idx >= data_lim;

  always_comb begin
    st_d    = st_q;
    kind_d  = kind_q;
    kind_en = 1'b0;
    unique case (st_q)
      RK_ON: begin
        if (expire) begin
          st_d    = RK_DOWN;
          kind_en = 1'b1;
          if (bank_open)     kind_d = PDK_ACT;
          else if (slow_sel) kind_d = PDK_SLOW;
          else               kind_d = PDK_FAST;
        end
      end
      RK_DOWN: begin
        if (req && dwell_met) st_d = RK_WAKE;
      end
      RK_WAKE: begin
        if (data_met) begin
          st_d    = RK_ON;
          kind_en = 1'b1;
          kind_d  = PDK_NONE;
        end
      end
      default: st_d = RK_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RK_ON;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       kind_q <= PDK_NONE;
    else if (kind_en) kind_q <= kind_d;
  end

  always_comb begin
    cke          = 1'b1;
    nop_stb      = 1'b0;
    pin_tristate = 1'b0;
    cmd_rdy      = 1'b1;
    data_rdy     = 1'b1;
    unique case (st_q)
      RK_DOWN: begin
        cke          = 1'b0;
        nop_stb      = (dwell == '0);
        pin_tristate = (dwell != '0);
        cmd_rdy      = 1'b0;
        data_rdy     = 1'b0;
      end
      RK_WAKE: begin
        nop_stb  = (wake_idx == '0);
        cmd_rdy  = cmd_met;
        data_rdy = data_met;
      end
      default: ;
    endcase
  end

  assign kind = kind_q;
endmodule

// File: rtl/dram_pd_ctrl.sv
module dram_pd_ctrl #(
  parameter int NUM_RANKS = 4,
  parameter int TMR_W     = 8,
  parameter int DLY_W     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_RANKS-1:0]       cfg_pd_en,
  input  logic                       cfg_slow_exit,
  input  logic [NUM_RANKS*TMR_W-1:0] cfg_idle_limit,
  input  logic [DLY_W-1:0]           cfg_min_pd,
  input  logic [DLY_W-1:0]           cfg_cmd_dly,
  input  logic [DLY_W-1:0]           cfg_data_dly,
  input  logic [NUM_RANKS-1:0]       req,
  input  logic [NUM_RANKS-1:0]       rd,
  input  logic [NUM_RANKS-1:0]       bank_open,
  output logic [NUM_RANKS-1:0]       cke,
  output logic [NUM_RANKS-1:0]       nop_stb,
  output logic [NUM_RANKS-1:0]       pin_tristate,
  output logic [NUM_RANKS-1:0]       cmd_rdy,
  output logic [NUM_RANKS-1:0]       data_rdy,
  output logic [2*NUM_RANKS-1:0]     pd_kind
);
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    dram_pd_rank #(.TMR_W(TMR_W), .DLY_W(DLY_W)) u_rank (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (cfg_pd_en[r]),
      .slow_sel     (cfg_slow_exit),
      .idle_limit   (cfg_idle_limit[r*TMR_W +: TMR_W]),
      .min_pd       (cfg_min_pd),
      .cmd_dly      (cfg_cmd_dly),
      .data_dly     (cfg_data_dly),
      .req          (req[r]),
      .rd           (rd[r]),
      .bank_open    (bank_open[r]),
      .cke          (cke[r]),
      .nop_stb      (nop_stb[r]),
      .pin_tristate (pin_tristate[r]),
      .cmd_rdy      (cmd_rdy[r]),
      .data_rdy     (data_rdy[r]),
      .kind         (pd_kind[2*r +: 2])
    );
  end
endmodule

// File: rtl/dram_pd_ctrl_chk.sv
module dram_pd_ctrl_chk #(
  parameter int NUM_RANKS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NUM_RANKS-1:0]   cfg_pd_en,
  input logic [NUM_RANKS-1:0]   cke,
  input logic [NUM_RANKS-1:0]   nop_stb,
  input logic [NUM_RANKS-1:0]   pin_tristate,
  input logic [NUM_RANKS-1:0]   cmd_rdy,
  input logic [NUM_RANKS-1:0]   data_rdy,
  input logic [2*NUM_RANKS-1:0] pd_kind
);
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    p_disabled_stays_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_pd_en[r] && cke[r]) |=> cke[r]);
    p_entry_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cke[r]) |-> (nop_stb[r] && !pin_tristate[r]));
    p_float_only_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pin_tristate[r] |-> (!cke[r] && !nop_stb[r]));
    p_no_ready_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !cke[r] |-> (!cmd_rdy[r] && !data_rdy[r]));
    p_kind_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cke[r] |-> (pd_kind[2*r +: 2] != 2'd0));
    p_kind_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke[r] && !$rose(cke[r])) |=> $stable(pd_kind[2*r +: 2]));
    p_exit_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cke[r]) |-> (nop_stb[r] && !pin_tristate[r]));
    p_cmd_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      data_rdy[r] |-> cmd_rdy[r]);
    p_awake_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_kind[2*r +: 2] == 2'd0) |-> (cke[r] && cmd_rdy[r] && data_rdy[r]));
  end
endmodule

bind dram_pd_ctrl dram_pd_ctrl_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_pd_en    (cfg_pd_en),
  .cke          (cke),
  .nop_stb      (nop_stb),
  .pin_tristate (pin_tristate),
  .cmd_rdy      (cmd_rdy),
  .data_rdy     (data_rdy),
  .pd_kind      (pd_kind)
);

// File: tb/dram_pd_ctrl_test.sv
`timescale 1ns/1ps
module dram_pd_ctrl_test;
  localparam int NR = 4;
  localparam int TW = 8;
  localparam int DW = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [NR-1:0]    cfg_pd_en;
  logic             cfg_slow_exit;
  logic [NR*TW-1:0] cfg_idle_limit;
  logic [DW-1:0]    cfg_min_pd, cfg_cmd_dly, cfg_data_dly;
  logic [NR-1:0]    req, rd, bank_open;
  logic [NR-1:0]    cke, nop_stb, pin_tristate, cmd_rdy, data_rdy;
  logic [2*NR-1:0]  pd_kind;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  dram_pd_ctrl #(.NUM_RANKS(NR), .TMR_W(TW), .DLY_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_pd_en(cfg_pd_en), .cfg_slow_exit(cfg_slow_exit),
    .cfg_idle_limit(cfg_idle_limit), .cfg_min_pd(cfg_min_pd), .cfg_cmd_dly(cfg_cmd_dly),
    .cfg_data_dly(cfg_data_dly), .req(req), .rd(rd), .bank_open(bank_open),
    .cke(cke), .nop_stb(nop_stb), .pin_tristate(pin_tristate), .cmd_rdy(cmd_rdy),
    .data_rdy(data_rdy), .pd_kind(pd_kind));

  // behavioural model: 0 awake, 1 down, 2 waking
  int m_st[NR], m_idle[NR], m_dw[NR], m_ex[NR], m_kind[NR];

  function automatic int lim_of(int r);
    int a, b;
    a = int'(cfg_cmd_dly);
    b = int'(cfg_data_dly);
    if (m_kind[r] == 3 && b > a) return b;
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NR; r++) begin
        m_st[r] = 0; m_idle[r] = 0; m_dw[r] = 0; m_ex[r] = 0; m_kind[r] = 0;
      end
    end else begin
      for (int r = 0; r < NR; r++) begin
        int lim;
        lim = int'(cfg_idle_limit[r*TW +: TW]);
        if (m_st[r] == 0) begin
          if (req[r] || rd[r] || !cfg_pd_en[r]) m_idle[r] = 0;
          else if (lim != 0 && m_idle[r] == lim - 1) begin
            m_st[r] = 1; m_dw[r] = 0; m_idle[r] = 0;
            m_kind[r] = bank_open[r] ? 1 : (cfg_slow_exit ? 3 : 2);
          end else m_idle[r]++;
        end else if (m_st[r] == 1) begin
          if (req[r] && m_dw[r] + 1 >= int'(cfg_min_pd)) begin m_st[r] = 2; m_ex[r] = 0; end
          else if (m_dw[r] < 31) m_dw[r]++;
        end else begin
          if (m_ex[r] >= lim_of(r)) begin m_st[r] = 0; m_idle[r] = 0; m_kind[r] = 0; end
          else if (m_ex[r] < 31) m_ex[r]++;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    for (int r = 0; r < NR; r++) begin
      int e_cke, e_nop, e_tri, e_cr, e_dr;
      e_cke = (m_st[r] != 1);
      e_nop = (m_st[r] == 1 && m_dw[r] == 0) || (m_st[r] == 2 && m_ex[r] == 0);
      e_tri = (m_st[r] == 1 && m_dw[r] != 0);
      e_cr  = (m_st[r] == 0) || (m_st[r] == 2 && m_ex[r] >= int'(cfg_cmd_dly));
      e_dr  = (m_st[r] == 0) || (m_st[r] == 2 && m_ex[r] >= lim_of(r));
      chk(cke[r] == e_cke, "R2 cke", int'(cke[r]), e_cke);
      chk(nop_stb[r] == e_nop, "R3 nop_stb", int'(nop_stb[r]), e_nop);
      chk(pin_tristate[r] == e_tri, "R4 pin_tristate", int'(pin_tristate[r]), e_tri);
      chk(int'(pd_kind[2*r +: 2]) == m_kind[r], "R5 pd_kind", int'(pd_kind[2*r +: 2]), m_kind[r]);
      chk(cmd_rdy[r] == e_cr, "R8 cmd_rdy", int'(cmd_rdy[r]), e_cr);
      chk(data_rdy[r] == e_dr, "R9 data_rdy", int'(data_rdy[r]), e_dr);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic count_until(input int r, input int sig, input bit val, output int n);
    n = 0;
    while (n < 100) begin
      bit s;
      case (sig)
        0: s = cke[r];
        1: s = cmd_rdy[r];
        default: s = data_rdy[r];
      endcase
      if (s == val) break;
      cyc();
      n++;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0;
    cfg_pd_en = '1; cfg_slow_exit = 1'b0;
    cfg_idle_limit = {8'd0, 8'd8, 8'd3, 8'd5};
    cfg_min_pd = 5'd3; cfg_cmd_dly = 5'd4; cfg_data_dly = 5'd16;
    req = '0; rd = '0; bank_open = 4'b0001;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cke == '1 && nop_stb == '0 && pin_tristate == '0, "R1 pins", int'(cke), 15);
    chk(cmd_rdy == '1 && data_rdy == '1 && pd_kind == '0, "R1 ready", int'(cmd_rdy), 15);
    rst_n = 1'b1;

    // R2 rank1 limit 3
    count_until(1, 0, 1'b0, n);
    chk(n == 3, "R2 idle limit rank1", n, 3);
    chk(nop_stb[1] == 1'b1 && pin_tristate[1] == 1'b0, "R3 entry nop", int'(nop_stb[1]), 1);
    chk(pd_kind[3:2] == 2'd2, "R5 fast kind", int'(pd_kind[3:2]), 2);
    // R6 request on the entry cycle: two more low cycles
    req[1] = 1'b1;
    cyc(); cyc();
    chk(pin_tristate[1] == 1'b1 && cke[1] == 1'b0, "R4 floating", int'(pin_tristate[1]), 1);
    count_until(1, 0, 1'b1, n);
    chk(n == 1, "R6 min dwell", n, 1);
    chk(nop_stb[1] == 1'b1 && pin_tristate[1] == 1'b0, "R7 exit nop", int'(nop_stb[1]), 1);
    chk(cke[0] == 1'b0 && pd_kind[1:0] == 2'd1, "R11 rank0 untouched", int'(cke[0]), 0);
    count_until(1, 1, 1'b1, n);
    chk(n == 4, "R8 cmd delay", n, 4);
    chk(data_rdy[1] == 1'b1, "R8 data with cmd", int'(data_rdy[1]), 1);
    chk(cke[3] == 1'b1, "R2 zero limit", int'(cke[3]), 1);
    req[1] = 1'b0;

    // R9 slow exit
    cfg_slow_exit = 1'b1;
    count_until(1, 0, 1'b0, n);
    chk(pd_kind[3:2] == 2'd3, "R5 slow kind", int'(pd_kind[3:2]), 3);
    req[1] = 1'b1;
    count_until(1, 0, 1'b1, n);
    count_until(1, 1, 1'b1, n);
    chk(n == 4, "R9 cmd delay slow", n, 4);
    count_until(1, 2, 1'b1, n);
    chk(n == 12, "R9 data delay slow", n, 12);
    req[1] = 1'b0;
    count_until(1, 0, 1'b0, n);
    chk(n == 4, "R10 idle restart", n, 4);

    // R2 enable off and read activity
    req[2] = 1'b1; cfg_pd_en[2] = 1'b0;
    repeat (25) cyc();
    req[2] = 1'b0;
    repeat (30) cyc();
    chk(cke[2] == 1'b1, "R2 disabled rank", int'(cke[2]), 1);
    cfg_pd_en[2] = 1'b1;
    for (int k = 0; k < 40; k++) begin
      rd[2] = (k % 6 == 5);
      cyc();
    end
    rd[2] = 1'b0;
    chk(cke[2] == 1'b1, "R2 reads restart", int'(cke[2]), 1);

    // random phase
    for (int k = 0; k < 6000; k++) begin
      if (k % 500 == 0) begin
        for (int r = 0; r < NR; r++) cfg_idle_limit[r*TW +: TW] = TW'($urandom_range(0, 6));
        cfg_min_pd    = DW'($urandom_range(0, 4));
        cfg_cmd_dly   = DW'($urandom_range(1, 5));
        cfg_data_dly  = DW'($urandom_range(0, 18));
        cfg_pd_en     = NR'($urandom_range(8, 15));
      end
      if (k % 37 == 0) cfg_slow_exit = 1'($urandom_range(0, 1));
      for (int r = 0; r < NR; r++) begin
        req[r]       = ($urandom_range(0, 9) == 0);
        rd[r]        = ($urandom_range(0, 15) == 0);
        bank_open[r] = 1'($urandom_range(0, 1));
      end
      cyc();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule